// File: doc/BRIEF.md
# Coupling-Aware Three-Way Inversion Link Codec

This block cuts the switching energy of an on-chip point-to-point link by sending each flit in one of three forms. The forms are the payload as it is, the payload with every odd-numbered line flipped, or the payload with every line flipped. For each flit the encoder estimates the crosstalk cost of each form against the word last driven onto the wires. It then sends the cheapest form that the far end can identify without doubt.

One extra wire carries a single flag that says whether any inversion happened. It does not say which kind. The decoder works out the kind itself. It runs a set of adjacent-line classifiers on the received word and its own copy of the previous word, then takes a majority vote over them. The encoder applies the same vote to each inverted candidate and rules out any candidate that would be misread. Decoding is therefore always exact.

The top module holds an encoder side and a decoder side with separate ports. A link under test can be looped back, or the two halves can sit at opposite ends of a real wire bundle.

Top module: `lc_link_codec`

## Requirements
- R1: The link word is W bits wide. Bit W-1 is the inversion flag. Bits W-2..0 are the N = W-1 data lines, and data line i carries payload bit i, possibly inverted.
- R2: The cost of sending word c after word p is summed over the N-1 adjacent line pairs (i, i+1). A pair costs 1 when exactly one of its two lines toggles. It costs 2 when both toggle and end with different values. It costs 0 otherwise. The flag line is not counted.
- R3: The encoder picks the action with the lowest cost among the admissible ones. The actions are none (payload), odd (payload XOR a mask whose bit i is 1 for odd i), and full (bitwise complement). On ties the order of preference is none, then odd, then full. None is always admissible.
- R4: The flag is 0 when the action is none and 1 for both odd and full. The data lines carry the payload, the odd-masked payload, or the complement, to match the action.
- R5: The encoder output is registered. One cycle after a cycle with tx_valid_i high, link_valid_o is 1 and link_word_o carries the new word. After a cycle with tx_valid_i low, link_valid_o is 0 and link_word_o keeps its value.
- R6: During reset the previous-word registers of both sides become zero, link_word_o becomes zero, and both valid outputs become 0.
- R7: The voter takes a previous word p and a received word r. A pair counts as a vote when the odd-masked r would give that pair a strictly lower cost than r itself. The voter reports full when the vote count is more than floor((N-1)/2), and odd otherwise. The odd action is admissible only if the voter reports odd for its candidate. The full action is admissible only if the voter reports full for its candidate.
- R8: One cycle after rx_valid_i is high, rx_valid_o is 1 and rx_payload_o holds the decoded payload. A flag of 0 passes the data lines through unchanged. A flag of 1 applies the odd mask when the voter says odd and complements the word when it says full. The decoder's previous word is updated only on valid cycles.
- R9: When the link output feeds the decoder input, every payload comes back unchanged. This holds for all-zero, all-one, alternating and random streams, including streams with idle gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid_i | input | 1 | Payload present this cycle |
| tx_payload_i | input | W-1 | Payload to encode |
| link_valid_o | output | 1 | Link word carries a new flit |
| link_word_o | output | W | Encoded word: flag in the top bit, data lines below it |
| rx_valid_i | input | 1 | Received link word is new this cycle |
| rx_word_i | input | W | Received link word |
| rx_valid_o | output | 1 | Decoded payload is valid |
| rx_payload_o | output | W-1 | Restored payload |

## Verification
Some properties are checked on every cycle. The reset values and the valid pipelines on both sides are checked this way. So is the holding of the link word while idle. Two more per-cycle checks are that the chosen action never costs more than sending the payload plainly, and that a word with a clear flag passes through the decoder unchanged. Other behaviour only shows up over the scenario streams. This covers whether the right action was chosen among three, whether the odd-or-full vote is correct, and whether decode always undoes encode across long histories, tie cases and patterns with idle gaps.

// File: rtl/lc_pkg.sv
// Package: shared action type and the per-pair coupling cost used by both
// the encoder candidates and the decoder vote.
package lc_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_ODD  = 2'd1,
        ACT_FULL = 2'd2
    } act_e;

    // Cost of one adjacent pair moving from (pa,pb) to (ca,cb):
    // single toggle -> 1, opposite toggle -> 2, otherwise 0.
    function automatic logic [1:0] pair_cost(input logic pa, input logic pb,
                                             input logic ca, input logic cb);
        logic sa;
        logic sb;
        sa = pa ^ ca;
        sb = pb ^ cb;
        if (sa ^ sb)
            return 2'd1;
        else if (sa && sb && (ca ^ cb))
            return 2'd2;
        else
            return 2'd0;
    endfunction

endpackage

// File: rtl/lc_pair_cost.sv
// Module: sums the weighted coupling cost of sending cand_i after prev_i
// over all N-1 adjacent line pairs. Purely combinational.
// Assumes N >= 3.
module lc_pair_cost #(
    parameter int N  = 15,
    parameter int CW = $clog2(2 * (N - 1) + 1)
) (
    input  logic [N-1:0]  prev_i,
    input  logic [N-1:0]  cand_i,
    output logic [CW-1:0] cost_o
);
    import lc_pkg::*;

    logic [1:0] pc [N-2:0];

    // One cost cell per adjacent pair.
    for (genvar i = 0; i < N - 1; i++) begin : g_pair
        assign pc[i] = pair_cost(prev_i[i], prev_i[i+1], cand_i[i], cand_i[i+1]);
    end

    // Accumulate the pair costs.
    always_comb begin
        cost_o = '0;
        for (int i = 0; i < N - 1; i++)
            cost_o = cost_o + {{(CW-2){1'b0}}, pc[i]};
    end

endmodule

// File: rtl/lc_voter.sv
// Module: majority voter that tells an odd-inverted word from a fully
// inverted one. For each pair it asks whether odd-inverting recv_i would
// lower that pair's cost against prev_i. full_o is high when more than
// half of the N-1 pairs say so. Combinational. Assumes N >= 3.
module lc_voter #(
    parameter int N = 15
) (
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] recv_i,
    output logic         full_o
);
    import lc_pkg::*;

    localparam int CNTW = $clog2(N);
    localparam logic [CNTW-1:0] THR = CNTW'((N - 1) / 2);

    logic [N-2:0]    ty;
    logic [CNTW-1:0] cnt;

    // Per-pair test: is the odd-masked pair strictly cheaper?
    for (genvar i = 0; i < N - 1; i++) begin : g_ty
        localparam logic MA = 1'(i % 2);
        localparam logic MB = 1'((i + 1) % 2);
        assign ty[i] = pair_cost(prev_i[i], prev_i[i+1], recv_i[i] ^ MA, recv_i[i+1] ^ MB)
                     < pair_cost(prev_i[i], prev_i[i+1], recv_i[i], recv_i[i+1]);
    end

    // Count the votes and compare with the majority threshold.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N - 1; i++)
            cnt = cnt + {{(CNTW-1){1'b0}}, ty[i]};
        full_o = (cnt > THR);
    end

endmodule

// File: rtl/lc_encoder.sv
// Module: builds three candidates per flit and costs each against the last
// driven word. It keeps only those the voter will classify correctly, and
// registers the cheapest one (ties: none, odd, full) with its flag.
// Assumes W >= 4. The link word register doubles as previous-word state.
module lc_encoder #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-2:0] in_payload,
    output logic         link_valid,
    output logic [W-1:0] link_word
);
    import lc_pkg::*;

    localparam int N  = W - 1;
    localparam int CW = $clog2(2 * (N - 1) + 1);

    logic [N-1:0]  odd_mask;
    logic [N-1:0]  cand_odd;
    logic [N-1:0]  cand_full;
    logic [CW-1:0] cost_none;
    logic [CW-1:0] cost_odd;
    logic [CW-1:0] cost_full;
    logic [CW-1:0] best_cost;
    logic          vote_odd;
    logic          vote_full;
    act_e          act;
    logic [W-1:0]  word_next;
    logic [W-1:0]  word_q;
    logic          valid_q;

    // Mask that selects the odd-numbered data lines.
    for (genvar i = 0; i < N; i++) begin : g_mask
        assign odd_mask[i] = 1'(i % 2);
    end

    assign cand_odd  = in_payload ^ odd_mask;
    assign cand_full = ~in_payload;

    lc_pair_cost #(.N(N), .CW(CW)) u_cost_none (
        .prev_i(word_q[N-1:0]), .cand_i(in_payload), .cost_o(cost_none));
    lc_pair_cost #(.N(N), .CW(CW)) u_cost_odd (
        .prev_i(word_q[N-1:0]), .cand_i(cand_odd),   .cost_o(cost_odd));
    lc_pair_cost #(.N(N), .CW(CW)) u_cost_full (
        .prev_i(word_q[N-1:0]), .cand_i(cand_full),  .cost_o(cost_full));

    lc_voter #(.N(N)) u_vote_odd (
        .prev_i(word_q[N-1:0]), .recv_i(cand_odd),  .full_o(vote_odd));
    lc_voter #(.N(N)) u_vote_full (
        .prev_i(word_q[N-1:0]), .recv_i(cand_full), .full_o(vote_full));

    // Pick the cheapest decodable action, preferring none, then odd.
    always_comb begin
        act       = ACT_NONE;
        best_cost = cost_none;
        if (!vote_odd && (cost_odd < best_cost)) begin
            act       = ACT_ODD;
            best_cost = cost_odd;
        end
        if (vote_full && (cost_full < best_cost)) begin
            act       = ACT_FULL;
            best_cost = cost_full;
        end
    end

    // Form the link word for the chosen action.
    always_comb begin
        case (act)
            ACT_ODD:  word_next = {1'b1, cand_odd};
            ACT_FULL: word_next = {1'b1, cand_full};
            default:  word_next = {1'b0, in_payload};
        endcase
    end

    // Register the link word on accepted flits; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid)
                word_q <= word_next;
        end
    end

    assign link_word  = word_q;
    assign link_valid = valid_q;

    assert_reset_clear_R6: assert property (@(posedge clk)
        !rst_n |=> (word_q == '0 && !valid_q));

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(word_q) && !valid_q));

    assert_valid_pipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> valid_q);

    assert_no_worse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (best_cost <= cost_none));

endmodule

// File: rtl/lc_decoder.sv
// Module: restores the payload from a received link word. With the flag
// clear the data passes through. With the flag set the voter, using the
// stored previous word, picks odd-mask or complement. Output registered.
// Assumes the sender's encoder starts from the same zero history.
module lc_decoder #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_word,
    output logic         out_valid,
    output logic [W-2:0] out_payload
);
    localparam int N = W - 1;

    logic [N-1:0] odd_mask;
    logic [N-1:0] prev_q;
    logic [N-1:0] data_in;
    logic         flag_in;
    logic         is_full;
    logic [N-1:0] restored;
    logic [N-1:0] payload_q;
    logic         valid_q;

    // Mask that selects the odd-numbered data lines.
    for (genvar i = 0; i < N; i++) begin : g_mask
        assign odd_mask[i] = 1'(i % 2);
    end

    assign data_in = rx_word[N-1:0];
    assign flag_in = rx_word[W-1];

    lc_voter #(.N(N)) u_vote (
        .prev_i(prev_q), .recv_i(data_in), .full_o(is_full));

    // Undo the inversion named by the flag and the vote.
    always_comb begin
        if (!flag_in)
            restored = data_in;
        else if (is_full)
            restored = ~data_in;
        else
            restored = data_in ^ odd_mask;
    end

    // Keep received history and register the restored payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            payload_q <= '0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= rx_valid;
            if (rx_valid) begin
                prev_q    <= data_in;
                payload_q <= restored;
            end
        end
    end

    assign out_valid   = valid_q;
    assign out_payload = payload_q;

    assert_rx_reset_R6: assert property (@(posedge clk)
        !rst_n |=> (!valid_q && prev_q == '0));

    assert_rx_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> out_valid);

    assert_plain_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_word[W-1]) |=> (out_payload == $past(rx_word[W-2:0])));

    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(out_payload));

endmodule

// File: rtl/lc_link_codec.sv
// Module: top level pairing the encoder (transmit side) and decoder
// (receive side) of the three-way inversion link code. The two sides share
// no state; the link between them is external.
module lc_link_codec #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_valid_i,
    input  logic [W-2:0] tx_payload_i,
    output logic         link_valid_o,
    output logic [W-1:0] link_word_o,
    input  logic         rx_valid_i,
    input  logic [W-1:0] rx_word_i,
    output logic         rx_valid_o,
    output logic [W-2:0] rx_payload_o
);

    lc_encoder #(.W(W)) u_enc (
        .clk(clk), .rst_n(rst_n),
        .in_valid(tx_valid_i), .in_payload(tx_payload_i),
        .link_valid(link_valid_o), .link_word(link_word_o));

    lc_decoder #(.W(W)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid_i), .rx_word(rx_word_i),
        .out_valid(rx_valid_o), .out_payload(rx_payload_o));

endmodule

// File: tb/lc_link_codec_test.sv
// Scoreboard bench: the driver models the encoder from the requirements and
// queues expected link words and payloads; a monitor pops and compares.
module lc_link_codec_test;

    localparam int W = 16;
    localparam int N = W - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_valid = 1'b0;
    logic [N-1:0] tx_payload = '0;
    logic         link_valid;
    logic [W-1:0] link_word;
    logic         rx_valid;
    logic [N-1:0] rx_payload;

    int n_checks = 0;
    int n_fail   = 0;
    int n_odd    = 0;
    int n_full   = 0;
    bit done     = 1'b0;

    logic [W-1:0] exp_word_q[$];
    logic [N-1:0] exp_pay_q[$];
    logic [N-1:0] m_prev = '0;
    logic [W-1:0] last_word = '0;

    always #2 clk = ~clk;

    // Link looped back from encoder to decoder.
    lc_link_codec #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid_i(tx_valid), .tx_payload_i(tx_payload),
        .link_valid_o(link_valid), .link_word_o(link_word),
        .rx_valid_i(link_valid), .rx_word_i(link_word),
        .rx_valid_o(rx_valid), .rx_payload_o(rx_payload));

    function automatic logic [N-1:0] odd_m();
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) m[i] = (i % 2 == 1);
        return m;
    endfunction

    // R2 pair cost model.
    function automatic int pcost(logic pa, logic pb, logic ca, logic cb);
        logic sa, sb;
        sa = pa ^ ca; sb = pb ^ cb;
        if (sa != sb) return 1;
        if (sa && sb && (ca != cb)) return 2;
        return 0;
    endfunction

    function automatic int wcost(logic [N-1:0] p, logic [N-1:0] c);
        int s = 0;
        for (int i = 0; i < N - 1; i++) s += pcost(p[i], p[i+1], c[i], c[i+1]);
        return s;
    endfunction

    // R7 voter model: 1 means full.
    function automatic bit vote(logic [N-1:0] p, logic [N-1:0] r);
        logic [N-1:0] a;
        int cnt = 0;
        a = r ^ odd_m();
        for (int i = 0; i < N - 1; i++)
            if (pcost(p[i], p[i+1], a[i], a[i+1]) < pcost(p[i], p[i+1], r[i], r[i+1])) cnt++;
        return (cnt * 2 > N - 1);
    endfunction

    // R3/R4 encoder model.
    function automatic logic [W-1:0] model_enc(logic [N-1:0] p, logic [N-1:0] x, output int act);
        int c0, c1, c2, best;
        logic [N-1:0] xo, xf;
        xo = x ^ odd_m(); xf = ~x;
        c0 = wcost(p, x); c1 = wcost(p, xo); c2 = wcost(p, xf);
        act = 0; best = c0;
        if (!vote(p, xo) && c1 < best) begin act = 1; best = c1; end
        if (vote(p, xf) && c2 < best) begin act = 2; best = c2; end
        if (act == 1) return {1'b1, xo};
        if (act == 2) return {1'b1, xf};
        return {1'b0, x};
    endfunction

    task automatic check(bit ok, string req, logic [W-1:0] act_v, logic [W-1:0] exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    task automatic send(logic [N-1:0] x);
        int a;
        logic [W-1:0] w;
        @(negedge clk);
        tx_valid   = 1'b1;
        tx_payload = x;
        w = model_enc(m_prev, x, a);
        if (a == 1) n_odd++;
        if (a == 2) n_full++;
        m_prev    = w[N-1:0];
        last_word = w;
        exp_word_q.push_back(w);
        exp_pay_q.push_back(x);
    endtask

    // R5: idle keeps the link word and drops valid.
    task automatic idle_check();
        @(negedge clk);
        tx_valid = 1'b0;
        @(negedge clk);
        check(link_word == last_word && !link_valid, "R5 idle hold",
              {link_valid, link_word[W-2:0]}, {1'b0, last_word[W-2:0]});
    endtask

    // Monitor: compare link words (R1 R3 R4) and payloads (R8 R9).
    always @(negedge clk) begin
        if (rst_n && link_valid) begin
            if (exp_word_q.size() == 0)
                check(1'b0, "R4 unexpected link word", link_word, '0);
            else begin
                logic [W-1:0] e;
                e = exp_word_q.pop_front();
                check(link_word == e, "R1/R3/R4 link word", link_word, e);
            end
        end
        if (rst_n && rx_valid) begin
            if (exp_pay_q.size() == 0)
                check(1'b0, "R8 unexpected payload", {1'b0, rx_payload}, '0);
            else begin
                logic [N-1:0] e;
                e = exp_pay_q.pop_front();
                check(rx_payload == e, "R8/R9 round trip", {1'b0, rx_payload}, {1'b0, e});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6 reset state.
        check(link_word == '0 && !link_valid && !rx_valid, "R6 reset",
              {link_valid, link_word[W-2:0]}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!link_valid && !rx_valid, "R6 after release",
              {15'd0, link_valid}, '0);

        // R9 all-zero stream.
        for (int i = 0; i < 8; i++) send('0);
        // R9 all-one and alternating patterns (R7 vote exercised).
        for (int i = 0; i < 8; i++) send('1);
        for (int i = 0; i < 12; i++) send((i % 2) ? {(N+1)/2{2'b01}} : {(N+1)/2{2'b10}});
        for (int i = 0; i < 6; i++) send({(N+1)/2{2'b01}});
        idle_check();
        // Walking one and its complement.
        for (int i = 0; i < N; i++) send(N'(1) << i);
        for (int i = 0; i < N; i++) send(~(N'(1) << i));
        idle_check();
        // Long random stream with gaps.
        for (int i = 0; i < 4000; i++) begin
            send(N'($urandom));
            if ($urandom_range(0, 15) == 0) idle_check();
        end
        idle_check();
        repeat (4) @(negedge clk);
        check(exp_word_q.size() == 0 && exp_pay_q.size() == 0, "R8 all flits returned",
              W'(exp_pay_q.size()), '0);
        $display("inversions: odd=%0d full=%0d", n_odd, n_full);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule